// File: doc/BRIEF.md
# Self-Checking Dual-Rail Word Comparator

This block checks two replicated copies of a word. Each bit of each copy arrives as a dual-rail pair: a "true" rail and a "false" rail that are complementary while the source is healthy. One comparison cell per bit lane turns the two pairs into a dual-rail "lanes differ" pair. A reduction tree of merge cells then folds these per-lane pairs into one result pair.

Every signal inside the block stays dual-rail coded. For this reason, a rail that sticks high or low between cells can never yield a wrong answer that looks valid. The result pair is either correct, or it becomes a non-code word (00 or 11), which the output decoder reports as a checker fault.

A fault-injection hook can force any inter-cell rail to a stuck value. A bench uses it to demonstrate the self-testing and fault-secure properties. Operational logic ties the hook's enable low. An optional output register breaks the timing path after the tree.

Top module: `dr_tsc_compare`

## Requirements
- R1: A logical 1 on lane i is carried as true rail 1 / false rail 0, and a logical 0 as true rail 0 / false rail 1. A pair whose two rails differ is a code word.
- R2: With both input words fully coded and no fault injected, `mismatch` is 1 exactly when some lane of A differs from the same lane of B. `equal` is 1 exactly when all lanes agree, and `checker_fault` is 0.
- R3: The result pair (`res_t`, `res_f`) is 10 for a mismatch and 01 for agreement. Exactly one of `equal`, `mismatch`, `checker_fault` is 1 in every cycle, and `checker_fault` marks a result pair of 00 or 11.
- R4: If any lane of either input carries 00 or 11, `checker_fault` is 1 and both `equal` and `mismatch` are 0, whatever the other lanes hold.
- R5: Fault sites are numbered as follows, with LANES lanes and NODES = 2*LANES-1 tree nodes. Lane i uses site 4i for A true, 4i+1 for A false, 4i+2 for B true and 4i+3 for B false. Node k (k < LANES is the comparison cell of lane k; node LANES+j merges nodes 2j and 2j+1) drives site 4*LANES+2k on its true output and 4*LANES+2k+1 on its false output. The last node is the root. While `fi_en` is 1, the selected rail is forced to `fi_val`. While `fi_en` is 0, `fi_site` and `fi_val` have no effect.
- R6: With one site stuck and fully coded inputs, the block either reports the correct `equal`/`mismatch` value or raises `checker_fault`. It never reports the wrong comparison result.
- R7: For every site and each stuck value, at least one fully coded input pair drives `checker_fault` to 1.
- R8: With REG_OUT = 1, the outputs reflect the inputs sampled at the previous rising clock edge. While `rst_n` is low, the result pair is 01 (`equal` = 1). With REG_OUT = 0, the outputs follow the inputs combinationally.
- R9: For a lane count that is not a power of two, a difference on any single lane alone still yields `mismatch`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| a_t | input | LANES | Copy A, true rails |
| a_f | input | LANES | Copy A, false rails |
| b_t | input | LANES | Copy B, true rails |
| b_f | input | LANES | Copy B, false rails |
| fi_en | input | 1 | Enables the stuck-at force on one site |
| fi_site | input | SITE_W | Index of the rail to force (numbering in R5) |
| fi_val | input | 1 | Value forced onto the selected rail |
| res_t | output | 1 | Result pair, true rail (1 = words differ) |
| res_f | output | 1 | Result pair, false rail |
| equal | output | 1 | Code-word result: all lanes agree |
| mismatch | output | 1 | Code-word result: some lane differs |
| checker_fault | output | 1 | Result pair is a non-code word |

## Verification
The bench builds the block with LANES = 5 and REG_OUT = 1. Five lanes give a nine-node tree whose fifth lane reaches the root through an extra merge level, which exercises the uneven tree shape. Five lanes also keep the code input space at 1024 word pairs, small enough to sweep every pair under every one of the 38 sites stuck at both values. The registered variant brings the one-cycle latency and the reset value of the result pair within reach of direct checks.

// File: rtl/dr_pkg.sv
`timescale 1ns/1ps
package dr_pkg;

    // One dual-rail coded bit: code words are {t,f} = 10 (logical 1) and 01 (logical 0).
    typedef struct packed {
        logic t;
        logic f;
    } dr_pair_t;

    // Logical 0, used as the reset value of the result pair (reads as "equal").
    localparam dr_pair_t DR_ZERO = '{t: 1'b0, f: 1'b1};

endpackage

// File: rtl/dr_cmp_cell.sv
`timescale 1ns/1ps
// Two-input dual-rail comparator cell: result carries x XOR y on its true rail.
// A non-code word on either input gives a non-code word on the output.
module dr_cmp_cell
    import dr_pkg::*;
(
    input  dr_pair_t x_i,
    input  dr_pair_t y_i,
    output dr_pair_t c_o
);

    always_comb begin
        c_o.t = (x_i.t & y_i.f) | (x_i.f & y_i.t);
        c_o.f = (x_i.t & y_i.t) | (x_i.f & y_i.f);
    end

endmodule

// File: rtl/dr_merge_cell.sv
`timescale 1ns/1ps
// Dual-rail OR of two "differs" pairs. Any non-code input collapses the output to 00.
module dr_merge_cell
    import dr_pkg::*;
(
    input  dr_pair_t x_i,
    input  dr_pair_t y_i,
    output dr_pair_t m_o
);

    logic both_code;

    always_comb begin
        both_code = (x_i.t ^ x_i.f) & (y_i.t ^ y_i.f);
        m_o.t     = both_code & (x_i.t | y_i.t);
        m_o.f     = both_code & x_i.f & y_i.f;
    end

endmodule

// File: rtl/dr_fault_tap.sv
`timescale 1ns/1ps
// Stuck-at force point on one dual-rail pair. The true rail is site BASE,
// the false rail is site BASE+1.
module dr_fault_tap
    import dr_pkg::*;
#(
    parameter int SITE_W = 6,
    parameter int BASE   = 0
) (
    input  dr_pair_t          p_i,
    input  logic              fi_en,
    input  logic [SITE_W-1:0] fi_site,
    input  logic              fi_val,
    output dr_pair_t          p_o
);

    localparam logic [SITE_W-1:0] SITE_T = SITE_W'(BASE);
    localparam logic [SITE_W-1:0] SITE_F = SITE_W'(BASE + 1);

    always_comb begin
        p_o.t = (fi_en && fi_site == SITE_T) ? fi_val : p_i.t;
        p_o.f = (fi_en && fi_site == SITE_F) ? fi_val : p_i.f;
    end

endmodule

// File: rtl/dr_tsc_compare.sv
`timescale 1ns/1ps
module dr_tsc_compare
    import dr_pkg::*;
#(
    parameter int  LANES   = 8,
    parameter bit  REG_OUT = 1'b1,
    localparam int NODES   = 2 * LANES - 1,
    localparam int SITES   = 4 * LANES + 2 * NODES,
    localparam int SITE_W  = $clog2(SITES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANES-1:0]  a_t,
    input  logic [LANES-1:0]  a_f,
    input  logic [LANES-1:0]  b_t,
    input  logic [LANES-1:0]  b_f,
    input  logic              fi_en,
    input  logic [SITE_W-1:0] fi_site,
    input  logic              fi_val,
    output logic              res_t,
    output logic              res_f,
    output logic              equal,
    output logic              mismatch,
    output logic              checker_fault
);

    localparam int NODE_BASE = 4 * LANES;

    dr_pair_t a_raw    [LANES];
    dr_pair_t b_raw    [LANES];
    dr_pair_t a_tap    [LANES];
    dr_pair_t b_tap    [LANES];
    dr_pair_t node_raw [NODES];
    dr_pair_t node_tap [NODES];

    // Leaf level: per-lane input taps and comparator cells.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign a_raw[i] = '{t: a_t[i], f: a_f[i]};
        assign b_raw[i] = '{t: b_t[i], f: b_f[i]};

        dr_fault_tap #(.SITE_W(SITE_W), .BASE(4 * i)) u_tap_a (
            .p_i(a_raw[i]), .fi_en(fi_en), .fi_site(fi_site), .fi_val(fi_val), .p_o(a_tap[i])
        );
        dr_fault_tap #(.SITE_W(SITE_W), .BASE(4 * i + 2)) u_tap_b (
            .p_i(b_raw[i]), .fi_en(fi_en), .fi_site(fi_site), .fi_val(fi_val), .p_o(b_tap[i])
        );

        dr_cmp_cell u_cmp (
            .x_i(a_tap[i]), .y_i(b_tap[i]), .c_o(node_raw[i])
        );

        dr_fault_tap #(.SITE_W(SITE_W), .BASE(NODE_BASE + 2 * i)) u_tap_n (
            .p_i(node_raw[i]), .fi_en(fi_en), .fi_site(fi_site), .fi_val(fi_val), .p_o(node_tap[i])
        );
    end

    // Reduction: node LANES+j merges nodes 2j and 2j+1; this queue order
    // builds a complete binary tree for any lane count, root at NODES-1.
    for (genvar j = 0; j < LANES - 1; j++) begin : g_merge
        dr_merge_cell u_merge (
            .x_i(node_tap[2 * j]), .y_i(node_tap[2 * j + 1]), .m_o(node_raw[LANES + j])
        );

        dr_fault_tap #(.SITE_W(SITE_W), .BASE(NODE_BASE + 2 * (LANES + j))) u_tap_m (
            .p_i(node_raw[LANES + j]), .fi_en(fi_en), .fi_site(fi_site), .fi_val(fi_val),
            .p_o(node_tap[LANES + j])
        );
    end

    // Output stage: optional register in two-process form.
    dr_pair_t res_d;
    dr_pair_t res_q;

    if (REG_OUT) begin : g_reg
        always_comb begin
            res_d = node_tap[NODES-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                res_q <= DR_ZERO;
            end else begin
                res_q <= res_d;
            end
        end
    end else begin : g_comb
        always_comb begin
            res_d = node_tap[NODES-1];
            res_q = res_d;
        end
    end

    // Decode of the final pair into flags.
    always_comb begin
        res_t         = res_q.t;
        res_f         = res_q.f;
        checker_fault = ~(res_q.t ^ res_q.f);
        mismatch      = res_q.t & ~res_q.f;
        equal         = res_q.f & ~res_q.t;
    end

endmodule

// File: rtl/dr_tsc_compare_chk.sv
`timescale 1ns/1ps
module dr_tsc_compare_chk #(
    parameter int LANES   = 8,
    parameter bit REG_OUT = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LANES-1:0] a_t,
    input logic [LANES-1:0] a_f,
    input logic [LANES-1:0] b_t,
    input logic [LANES-1:0] b_f,
    input logic             fi_en,
    input logic             equal,
    input logic             mismatch,
    input logic             checker_fault
);

    logic in_code;
    logic words_differ;

    always_comb begin
        in_code      = (&(a_t ^ a_f)) & (&(b_t ^ b_f));
        words_differ = |(a_t ^ b_t);
    end

    // R3
    flags_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({equal, mismatch, checker_fault}) == 1);

    if (REG_OUT) begin : g_seq
        // R2
        clean_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!fi_en && in_code) |=> (!checker_fault && mismatch == $past(words_differ)));

        // R4
        noncode_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!fi_en && !in_code) |=> checker_fault);

        // R6
        fault_secure_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (fi_en && in_code) |=> (checker_fault || mismatch == $past(words_differ)));
    end else begin : g_comb
        // R2
        clean_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!fi_en && in_code) |-> (!checker_fault && mismatch == words_differ));

        // R4
        noncode_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!fi_en && !in_code) |-> checker_fault);

        // R6
        fault_secure_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (fi_en && in_code) |-> (checker_fault || mismatch == words_differ));
    end

endmodule

bind dr_tsc_compare dr_tsc_compare_chk #(
    .LANES(LANES),
    .REG_OUT(REG_OUT)
) chk_i (
    .clk(clk),
    .rst_n(rst_n),
    .a_t(a_t),
    .a_f(a_f),
    .b_t(b_t),
    .b_f(b_f),
    .fi_en(fi_en),
    .equal(equal),
    .mismatch(mismatch),
    .checker_fault(checker_fault)
);

// File: tb/dr_tsc_compare_tb_top.sv
`timescale 1ns/1ps
module dr_tsc_compare_tb_top;

    localparam int LANES  = 5;
    localparam int NODES  = 2 * LANES - 1;
    localparam int SITES  = 4 * LANES + 2 * NODES;
    localparam int SITE_W = $clog2(SITES);
    localparam int ROOT_T = 4 * LANES + 2 * (NODES - 1);

    // flag codes {equal, mismatch, checker_fault}
    localparam int F_EQ   = 4;
    localparam int F_MIS  = 2;
    localparam int F_BAD  = 1;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [LANES-1:0]  a_t, a_f, b_t, b_f;
    logic              fi_en;
    logic [SITE_W-1:0] fi_site;
    logic              fi_val;
    logic              res_t, res_f, equal, mismatch, checker_fault;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    dr_tsc_compare #(.LANES(LANES), .REG_OUT(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .a_t(a_t), .a_f(a_f), .b_t(b_t), .b_f(b_f),
        .fi_en(fi_en), .fi_site(fi_site), .fi_val(fi_val),
        .res_t(res_t), .res_f(res_f),
        .equal(equal), .mismatch(mismatch), .checker_fault(checker_fault)
    );

    function automatic int flags();
        return {29'd0, equal, mismatch, checker_fault};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [LANES-1:0] av, input logic [LANES-1:0] bv);
        a_t = av;
        a_f = ~av;
        b_t = bv;
        b_f = ~bv;
    endtask

    // R8: reset value of the result pair
    task automatic t_reset();
        rst_n   = 1'b0;
        fi_en   = 1'b0;
        fi_site = '0;
        fi_val  = 1'b0;
        drive(5'h03, 5'h10);
        repeat (3) @(negedge clk);
        check(flags() == F_EQ, "R8", "flags in reset", flags(), F_EQ);
        check({res_t, res_f} == 2'b01, "R8", "pair in reset", {res_t, res_f}, 1);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // R8, R3: one-cycle latency and pair encoding
    task automatic t_latency();
        drive(5'h00, 5'h00);
        @(negedge clk);
        check(flags() == F_EQ, "R3", "equal words", flags(), F_EQ);
        check({res_t, res_f} == 2'b01, "R3", "pair for equal", {res_t, res_f}, 1);
        drive(5'h01, 5'h00);
        #1;
        check(flags() == F_EQ, "R8", "output held before edge", flags(), F_EQ);
        @(negedge clk);
        check(flags() == F_MIS, "R8", "output after edge", flags(), F_MIS);
        check({res_t, res_f} == 2'b10, "R3", "pair for mismatch", {res_t, res_f}, 2);
    endtask

    // R1, R2: every coded word pair without faults
    task automatic t_fault_free();
        for (int av = 0; av < 32; av++) begin
            for (int bv = 0; bv < 32; bv++) begin
                int exp;
                drive(av[LANES-1:0], bv[LANES-1:0]);
                @(negedge clk);
                exp = (av != bv) ? F_MIS : F_EQ;
                check(flags() == exp, "R2", "coded compare", flags(), exp);
            end
        end
        drive(5'h1F, 5'h1F);
        @(negedge clk);
        check(flags() == F_EQ, "R1", "all ones both copies", flags(), F_EQ);
    endtask

    // R9: single-lane difference on each lane of the uneven tree
    task automatic t_single_lane();
        for (int ln = 0; ln < LANES; ln++) begin
            logic [LANES-1:0] base;
            base = 5'h0A;
            drive(base, base ^ (5'h01 << ln));
            @(negedge clk);
            check(flags() == F_MIS, "R9", $sformatf("lane %0d alone", ln), flags(), F_MIS);
        end
    endtask

    // R4: non-code words on one lane of either copy
    task automatic t_noncode();
        for (int ln = 0; ln < LANES; ln++) begin
            for (int side = 0; side < 2; side++) begin
                for (int pat = 0; pat < 2; pat++) begin
                    for (int bsel = 0; bsel < 2; bsel++) begin
                        logic [LANES-1:0] base;
                        base = bsel ? 5'h15 : 5'h00;
                        drive(base, bsel ? 5'h0B : base);
                        if (side == 0) begin
                            a_t[ln] = pat[0];
                            a_f[ln] = pat[0];
                        end else begin
                            b_t[ln] = pat[0];
                            b_f[ln] = pat[0];
                        end
                        @(negedge clk);
                        check(flags() == F_BAD, "R4",
                              $sformatf("non-code lane %0d side %0d", ln, side), flags(), F_BAD);
                    end
                end
            end
        end
    endtask

    // R5: site numbering and the enable
    task automatic t_site_map();
        fi_en = 1'b0; fi_site = SITE_W'(0); fi_val = 1'b1;
        drive(5'h00, 5'h00);
        @(negedge clk);
        check(flags() == F_EQ, "R5", "force disabled", flags(), F_EQ);

        fi_en = 1'b1; fi_site = SITE_W'(0); fi_val = 1'b1;
        @(negedge clk);
        check(flags() == F_BAD, "R5", "site 0 stuck 1", flags(), F_BAD);

        fi_site = SITE_W'(ROOT_T); fi_val = 1'b1;
        drive(5'h03, 5'h03);
        @(negedge clk);
        check({res_t, res_f} == 2'b11, "R5", "root true stuck 1 pair", {res_t, res_f}, 3);

        fi_site = SITE_W'(ROOT_T + 1); fi_val = 1'b0;
        @(negedge clk);
        check({res_t, res_f} == 2'b00, "R5", "root false stuck 0 pair", {res_t, res_f}, 0);

        fi_site = SITE_W'(ROOT_T); fi_val = 1'b1;
        drive(5'h01, 5'h00);
        @(negedge clk);
        check(flags() == F_MIS, "R5", "root stuck at its own value", flags(), F_MIS);
        fi_en = 1'b0;
    endtask

    // R6, R7: every site, both stuck values, every coded word pair
    task automatic t_fault_sweep();
        for (int s = 0; s < SITES; s++) begin
            for (int v = 0; v < 2; v++) begin
                bit seen_bad;
                seen_bad = 1'b0;
                fi_en   = 1'b1;
                fi_site = SITE_W'(s);
                fi_val  = v[0];
                for (int av = 0; av < 32; av++) begin
                    for (int bv = 0; bv < 32; bv++) begin
                        int exp;
                        drive(av[LANES-1:0], bv[LANES-1:0]);
                        @(negedge clk);
                        exp = (av != bv) ? F_MIS : F_EQ;
                        if (checker_fault) begin
                            seen_bad = 1'b1;
                        end else begin
                            check(flags() == exp, "R6",
                                  $sformatf("site %0d stuck %0d", s, v), flags(), exp);
                        end
                    end
                end
                check(seen_bad, "R7", $sformatf("site %0d stuck %0d detected", s, v),
                      seen_bad, 1);
            end
        end
        fi_en = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        t_reset();
        t_latency();
        t_fault_free();
        t_single_lane();
        t_noncode();
        t_site_map();
        t_fault_sweep();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule